// File: doc/BRIEF.md
# Dual-Mode Control-Flow Trace Buffer

This block records control-flow trace words from a processor core into a 256-entry on-chip store. Software controls it through a small coprocessor-style register port, where a register number field picks the register and the remaining opcode fields must be zero. A control register turns capture on and off and selects one of two capture policies. The first is fill-once: capture stops when the store is full and a one-cycle debug exception is raised. The second is wrap: the store is written as a ring and the oldest words are overwritten until software disables capture.

Once capture is off, software drains the store through the data register. Each read returns the next stored word, newest first, and steps the pointer back by one. When the store is empty, a read returns zero. A software write to the data register while capture is off pushes a word, the same way a trace write does. A write to the data register while capture is on is dropped.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the enable bit, the mode bit, the pointer and the entry count are all zero, so reads of the control register and the data register both return 0.
- R2: The control register is register number 1. Bit 0 is the capture enable and bit 1 is the mode (1 = fill-once, 0 = wrap). A read returns these two bits and zeros in every other bit.
- R3: A write or read whose CRm, opcode-1 or opcode-2 field is nonzero has no effect on any state, and a read of that kind returns 0.
- R4: While capture is enabled, each cycle with `trc_valid` high stores `trc_data` as a new entry.
- R5: In fill-once mode, once 256 entries are held, further trace writes are dropped and the stored words stay unchanged.
- R6: In fill-once mode, the trace write that brings the count to 256 produces a `trc_full_exc` pulse exactly one cycle long, in the cycle after that write. Wrap mode never raises the pulse.
- R7: In wrap mode the write pointer wraps modulo 256 and the count saturates at 256, so the buffer then holds the 256 most recent entries.
- R8: The data register is register number 2. A read of it while capture is disabled returns the most recent remaining entry and removes it. `reg_rdata` shows the result in the cycle after the read strobe and holds it until the next read.
- R9: A data-register read from an empty buffer returns 0.
- R10: A data-register write is ignored while capture is enabled. While capture is disabled it stores `reg_wdata` as a new entry.
- R11: A data-register read while capture is enabled returns 0 and removes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trc_valid | input | 1 | Trace word strobe from the core |
| trc_data | input | 32 | Trace word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_crn | input | 4 | Register number select |
| reg_crm | input | 4 | Secondary field, must be zero |
| reg_op1 | input | 3 | Opcode-1 field, must be zero |
| reg_op2 | input | 3 | Opcode-2 field, must be zero |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| trc_full_exc | output | 1 | One-cycle debug exception pulse when the fill-once buffer becomes full |

## Verification
The assertions check several rules on every cycle. The count never exceeds the depth. The exception pulse lasts one cycle and appears only with a full count. The pointer stays frozen under trace writes to a full fill-once buffer. Empty reads yield zero, reads during capture do not change the count, and accesses with nonzero opcode fields leave the control state untouched. Only the bench scenarios can show the order of the data: newest-first draining, which words survive a wrap past 256 entries, and the fact that exactly one pulse occurs in a whole fill.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam logic [3:0] CRN_CTRL = 4'd1;
  localparam logic [3:0] CRN_DATA = 4'd2;

  typedef struct packed {
    logic fill_once;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tcb_store.sv
module tcb_store #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tcb_ptr.sv
module tcb_ptr #(
  parameter int DEPTH = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_once,
  input  logic             push,
  input  logic             push_is_trace,
  input  logic             pop,
  output logic             accept,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] top_addr,
  output logic [CNT_W-1:0] cnt,
  output logic             empty,
  output logic             exc
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] NEAR_CNT = CNT_W'(DEPTH - 1);

  logic             full, do_pop, ptr_en, exc_d;
  logic [PTR_W-1:0] ptr_inc, ptr_dec, ptr_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    full     = (cnt == FULL_CNT);
    empty    = (cnt == '0);
    ptr_inc  = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
    ptr_dec  = (wr_ptr == '0) ? LAST_IDX : wr_ptr - 1'b1;
    top_addr = ptr_dec;
    accept   = push && !(fill_once && full);
    do_pop   = pop && !push && !empty;
    ptr_en   = accept || do_pop;
    ptr_d    = wr_ptr;
    cnt_d    = cnt;
    if (accept) begin
      ptr_d = ptr_inc;
      cnt_d = full ? cnt : cnt + 1'b1;
    end else if (do_pop) begin
      ptr_d = ptr_dec;
      cnt_d = cnt - 1'b1;
    end
    exc_d = accept && push_is_trace && fill_once && (cnt == NEAR_CNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (ptr_en) begin
      wr_ptr <= ptr_d;
      cnt    <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exc <= 1'b0;
    else        exc <= exc_d;
  end
endmodule

// File: rtl/tcb_regif.sv
module tcb_regif
  import tcb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_crn,
  input  logic [3:0]        reg_crm,
  input  logic [2:0]        reg_op1,
  input  logic [2:0]        reg_op2,
  input  logic [1:0]        ctrl_wdata,
  input  logic [DATA_W-1:0] top_entry,
  input  logic              empty,
  output ctrl_t             ctrl_q,
  output logic              sw_push,
  output logic              pop,
  output logic [DATA_W-1:0] rdata_q
);
  logic              sel_ok, ctrl_we, rd_go, data_rd;
  ctrl_t             ctrl_d;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    sel_ok  = (reg_crm == '0) && (reg_op1 == '0) && (reg_op2 == '0);
    ctrl_we = reg_wr && sel_ok && (reg_crn == CRN_CTRL);
    ctrl_d  = ctrl_t'(ctrl_wdata);
    sw_push = reg_wr && sel_ok && (reg_crn == CRN_DATA) && !ctrl_q.en;
    rd_go   = reg_rd && !reg_wr;
    data_rd = rd_go && sel_ok && (reg_crn == CRN_DATA);
    pop     = data_rd && !ctrl_q.en;
    rdata_d = '0;
    if (rd_go && sel_ok && (reg_crn == CRN_CTRL))
      rdata_d = DATA_W'({ctrl_q.fill_once, ctrl_q.en});
    else if (pop && !empty)
      rdata_d = top_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_go) rdata_q <= rdata_d;
  end
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trc_valid,
  input  logic [DATA_W-1:0] trc_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_crn,
  input  logic [3:0]        reg_crm,
  input  logic [2:0]        reg_op1,
  input  logic [2:0]        reg_op2,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              trc_full_exc
);
  ctrl_t             ctrl_q;
  logic              sw_push, pop, trace_push, push, accept, empty;
  logic [PTR_W-1:0]  wr_ptr, top_addr;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] top_entry, store_wdata;

  assign trace_push  = trc_valid && ctrl_q.en;
  assign push        = trace_push || sw_push;
  assign store_wdata = ctrl_q.en ? trc_data : reg_wdata;

  tcb_regif #(.DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_crn(reg_crn), .reg_crm(reg_crm), .reg_op1(reg_op1), .reg_op2(reg_op2),
    .ctrl_wdata(reg_wdata[1:0]), .top_entry(top_entry), .empty(empty),
    .ctrl_q(ctrl_q), .sw_push(sw_push), .pop(pop), .rdata_q(reg_rdata)
  );

  tcb_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .fill_once(ctrl_q.fill_once), .push(push),
    .push_is_trace(trace_push), .pop(pop), .accept(accept), .wr_ptr(wr_ptr),
    .top_addr(top_addr), .cnt(cnt), .empty(empty), .exc(trc_full_exc)
  );

  tcb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(accept), .waddr(wr_ptr), .wdata(store_wdata),
    .raddr(top_addr), .rdata(top_entry)
  );
endmodule

// File: rtl/trace_capture_buf_chk.sv
module trace_capture_buf_chk #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc,
  input logic [CNT_W-1:0]  cnt,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic              en,
  input logic              fill_once,
  input logic              trc_valid,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [3:0]        reg_crn,
  input logic [3:0]        reg_crm,
  input logic [2:0]        reg_op1,
  input logic [2:0]        reg_op2,
  input logic [DATA_W-1:0] reg_rdata
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  logic bad_sel, data_rd;
  assign bad_sel = (reg_crm != '0) || (reg_op1 != '0) || (reg_op2 != '0);
  assign data_rd = reg_rd && !reg_wr && !bad_sel && (reg_crn == 4'd2);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  // R5
  full_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fill_once && cnt == FULL_CNT && trc_valid) |=> $stable(wr_ptr));

  // R6
  exc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc |=> !exc);

  // R6
  exc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (cnt == FULL_CNT));

  // R9
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && cnt == '0) |=> (reg_rdata == '0));

  // R11
  rd_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && en && !trc_valid) |=> $stable(cnt));

  // R3
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_sel && (reg_wr || reg_rd) && !trc_valid) |=> ($stable(cnt) && $stable(en) && $stable(fill_once)));
endmodule

bind trace_capture_buf trace_capture_buf_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc(trc_full_exc), .cnt(cnt), .wr_ptr(wr_ptr),
  .en(ctrl_q.en), .fill_once(ctrl_q.fill_once), .trc_valid(trc_valid),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_crn(reg_crn), .reg_crm(reg_crm),
  .reg_op1(reg_op1), .reg_op2(reg_op2), .reg_rdata(reg_rdata)
);

// File: tb/trace_capture_buf_test.sv
module trace_capture_buf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trc_valid = 1'b0;
  logic [31:0] trc_data = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_crn = '0, reg_crm = '0;
  logic [2:0]  reg_op1 = '0, reg_op2 = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        trc_full_exc;

  int checks = 0, errors = 0, pulses = 0;
  logic        last_exc;
  logic [31:0] rv;

  trace_capture_buf uut (
    .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_data(trc_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_crn(reg_crn), .reg_crm(reg_crm),
    .reg_op1(reg_op1), .reg_op2(reg_op2), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trc_full_exc(trc_full_exc)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (trc_full_exc) pulses++;

  // op: 0 trace write, 1 control write, 2 data write, 3 data read with expected
  localparam int NV = 12;
  localparam logic [65:0] VEC [NV] = '{
    {2'd1, 32'h1,  32'h0},   // R2 enable, wrap
    {2'd0, 32'hA1, 32'h0},   // R4
    {2'd0, 32'hB2, 32'h0},   // R4
    {2'd0, 32'hC3, 32'h0},   // R4
    {2'd2, 32'hDD, 32'h0},   // R10 ignored while enabled
    {2'd1, 32'h0,  32'h0},   // disable
    {2'd3, 32'h0,  32'hC3},  // R8 newest first
    {2'd2, 32'hE4, 32'h0},   // R10 stored while disabled
    {2'd3, 32'h0,  32'hE4},  // R10
    {2'd3, 32'h0,  32'hB2},  // R8
    {2'd3, 32'h0,  32'hA1},  // R8
    {2'd3, 32'h0,  32'h0}    // R9 empty
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic trace_push(input logic [31:0] d);
    @(negedge clk); trc_valid = 1'b1; trc_data = d;
    @(negedge clk); trc_valid = 1'b0; last_exc = trc_full_exc;
  endtask

  task automatic reg_write(input logic [3:0] crn, input logic [31:0] d, input logic [3:0] crm);
    @(negedge clk); reg_wr = 1'b1; reg_crn = crn; reg_wdata = d; reg_crm = crm;
    @(negedge clk); reg_wr = 1'b0; reg_crm = '0;
  endtask

  task automatic reg_read(input logic [3:0] crn, input logic [2:0] op1, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_crn = crn; reg_op1 = op1;
    @(negedge clk); reg_rd = 1'b0; reg_op1 = '0; d = reg_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    reg_read(4'd1, 3'd0, rv); check("R1 ctrl", rv, 32'h0);
    reg_read(4'd2, 3'd0, rv); check("R1 data", rv, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][65:64])
        2'd0: trace_push(VEC[i][63:32]);
        2'd1: reg_write(4'd1, VEC[i][63:32], 4'd0);
        2'd2: reg_write(4'd2, VEC[i][63:32], 4'd0);
        default: begin
          reg_read(4'd2, 3'd0, rv);
          check("R8/R9/R10 vector", rv, VEC[i][31:0]);
        end
      endcase
    end

    // R2 control readback, fill-once disabled
    reg_write(4'd1, 32'hFFFF_FFF2, 4'd0);
    reg_read(4'd1, 3'd0, rv); check("R2 ctrl", rv, 32'h2);
    // R3 nonzero CRm write ignored, nonzero op1 read returns 0
    reg_write(4'd1, 32'h1, 4'd3);
    reg_read(4'd1, 3'd0, rv); check("R3 write ignored", rv, 32'h2);
    reg_read(4'd1, 3'd5, rv); check("R3 read zero", rv, 32'h0);

    // R5/R6 fill-once
    reg_write(4'd1, 32'h3, 4'd0);
    for (int i = 0; i < 255; i++) trace_push(32'h100 + i);
    check("R6 no early pulse", 32'(pulses), 32'd0);
    trace_push(32'h1FF);
    check("R6 pulse on fill", {31'd0, last_exc}, 32'h1);
    @(negedge clk);
    check("R6 pulse one cycle", {31'd0, trc_full_exc}, 32'h0);
    trace_push(32'hBAD);
    check("R6 single pulse", 32'(pulses), 32'd1);
    // R11 read while enabled
    reg_read(4'd2, 3'd0, rv); check("R11 read enabled", rv, 32'h0);
    reg_write(4'd1, 32'h2, 4'd0);
    reg_read(4'd2, 3'd0, rv); check("R5 drop after full", rv, 32'h1FF);
    reg_read(4'd2, 3'd0, rv); check("R8 next", rv, 32'h1FE);
    for (int i = 0; i < 253; i++) reg_read(4'd2, 3'd0, rv);
    check("R8 oldest", rv, 32'h101);
    reg_read(4'd2, 3'd0, rv); check("R5 first entry", rv, 32'h100);
    reg_read(4'd2, 3'd0, rv); check("R9 drained", rv, 32'h0);

    // R7 wrap mode
    reg_write(4'd1, 32'h1, 4'd0);
    for (int i = 0; i < 260; i++) trace_push(32'h1000 + i);
    check("R6 no pulse in wrap", 32'(pulses), 32'd1);
    reg_write(4'd1, 32'h0, 4'd0);
    reg_read(4'd2, 3'd0, rv); check("R7 newest", rv, 32'h1000 + 259);
    for (int i = 0; i < 255; i++) reg_read(4'd2, 3'd0, rv);
    check("R7 oldest kept", rv, 32'h1004);
    reg_read(4'd2, 3'd0, rv); check("R7 saturated count", rv, 32'h0);

    // R1 reset mid-run
    reg_write(4'd1, 32'h1, 4'd0);
    trace_push(32'h55);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    reg_read(4'd1, 3'd0, rv); check("R1 ctrl after reset", rv, 32'h0);
    reg_read(4'd2, 3'd0, rv); check("R1 empty after reset", rv, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule